// File: doc/BRIEF.md
# Stack Pointer and Top-of-Memory Address Decoder

This block sits between an 8-bit CPU core and its 64 KiB data space. Every CPU data access is steered by its 16-bit address to one of four targets: general RAM in the low region, a character/attribute video window, a window of peripheral slots, or three byte-wide internal registers at the highest addresses. The internal registers are the status byte and the two halves of the hardware stack pointer, so software can read and rewrite them with ordinary loads and stores.

The block also owns the stack pointer and sequences stack operations over two cycles. A push latches the operand and the current pointer, decrements the pointer, and in the next cycle writes the operand to RAM at the latched address. A pop increments the pointer and in the next cycle issues a RAM read at the new pointer; the returned byte is taken by the core straight from RAM. Requests may be issued on consecutive cycles, and the RAM port is handed to the pending stack transfer ahead of any CPU access in that cycle.

Top module: `stack_mmio_decoder`

## Requirements
- R1: After reset the stack pointer is 0xEFFF and the status byte is 0x00; a read of 0xFFFE returns 0xFF, 0xFFFD returns 0xEF, 0xFFFF returns 0x00, and with no request pending no RAM enable is raised.
- R2: A push request raises `busy` in the cycle it is presented; in the next cycle `ram_we` is high, `ram_addr` holds the pointer value from the request cycle and `ram_wdata` holds the pushed byte, and the pointer has been decremented by one.
- R3: A pop request raises `busy` in the cycle it is presented; the pointer is incremented by one at that edge, and in the next cycle `ram_re` is high with `ram_addr` equal to the incremented pointer.
- R4: A CPU read or write to an address below 0xF000 drives `ram_addr` with that address and raises `ram_re` or `ram_we` accordingly (write data on `ram_wdata`), when no stack transfer is due in that cycle.
- R5: A CPU access to 0xF000 through 0xFFCF raises `vid_sel` and no RAM enable, peripheral select or register hit.
- R6: A CPU access to 0xFFD0 through 0xFFFC raises `per_sel` with `per_slot` equal to the address minus 0xFFD0 (0 to 44); without a read or write strobe no select is raised.
- R7: A write to 0xFFFF replaces the status byte; a read of 0xFFFF returns it on `reg_rdata`. `reg_rdata` is 0x00 unless a register address (0xFFFD to 0xFFFF) is being read.
- R8: A write to 0xFFFE replaces only the low byte of the pointer and a write to 0xFFFD only the high byte; reads of those addresses return the matching byte in the same cycle.
- R9: When a pointer-byte write coincides with a push or pop request, the written half takes the write data and the other half keeps its value from before the request; the increment or decrement is discarded, while the stack RAM transfer still occurs at the address computed from the old pointer.
- R10: The pointer wraps modulo 65536: a push at 0x0000 leaves 0xFFFF, and a pop at 0xFFFF moves it to 0x0000 and reads RAM at 0x0000.
- R11: In a cycle where a stack transfer is due, the RAM port carries that transfer regardless of any CPU RAM access; when push and pop are requested together, the push is performed and the pop is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU data address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| push_req | input | 1 | Stack push request |
| pop_req | input | 1 | Stack pop request |
| push_data | input | 8 | Byte to be pushed |
| ram_addr | output | 16 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable |
| vid_sel | output | 1 | Video window select |
| per_sel | output | 1 | Peripheral window select |
| per_slot | output | 6 | Peripheral slot index |
| reg_hit | output | 1 | Internal register access |
| reg_rdata | output | 8 | Internal register read data |
| busy | output | 1 | First cycle of a stack operation |

## Verification
The assertions assume the core never raises read and write strobes together and that a pointer-byte write coinciding with a stack request is a deliberate override, so the pointer-step checks are conditioned on the absence of such a write. The stimulus drives at most one strobe per cycle, keeps requests on single cycles or deliberate back-to-back pairs, and places each collision case (stack transfer against CPU RAM access, push against pop, pointer write against a request) in its own labelled step so the predicted RAM port and pointer value are unambiguous.

// File: rtl/stack_mmio_decoder.sv
module stack_mmio_decoder #(
  parameter int DW = 8,
  parameter logic [2*DW-1:0] SP_INIT   = 16'hEFFF,
  parameter logic [2*DW-1:0] VID_BASE  = 16'hF000,
  parameter logic [2*DW-1:0] PER_BASE  = 16'hFFD0,
  parameter logic [2*DW-1:0] SPH_ADDR  = 16'hFFFD,
  parameter logic [2*DW-1:0] SPL_ADDR  = 16'hFFFE,
  parameter logic [2*DW-1:0] SREG_ADDR = 16'hFFFF,
  localparam int AW = 2*DW,
  localparam int SLOT_W = $clog2(int'(SPH_ADDR - PER_BASE))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [DW-1:0]     push_data,
  output logic [AW-1:0]     ram_addr,
  output logic [DW-1:0]     ram_wdata,
  output logic              ram_we,
  output logic              ram_re,
  output logic              vid_sel,
  output logic              per_sel,
  output logic [SLOT_W-1:0] per_slot,
  output logic              reg_hit,
  output logic [DW-1:0]     reg_rdata,
  output logic              busy
);

  logic [AW-1:0] sp, sp_nxt, sp_inc, sp_dec, xf_addr;
  logic [DW-1:0] sreg, xf_data;
  logic          xf_act, xf_push;

  wire strobe = cpu_rd | cpu_wr;
  wire in_ram = cpu_addr < VID_BASE;
  wire in_vid = (cpu_addr >= VID_BASE) && (cpu_addr < PER_BASE);
  wire in_per = (cpu_addr >= PER_BASE) && (cpu_addr < SPH_ADDR);
  wire in_reg = cpu_addr >= SPH_ADDR;
  wire cpu_ram = strobe & in_ram;
  wire wr_spl = cpu_wr & (cpu_addr == SPL_ADDR);
  wire wr_sph = cpu_wr & (cpu_addr == SPH_ADDR);
  wire wr_srg = cpu_wr & (cpu_addr == SREG_ADDR);

  assign sp_inc = sp + AW'(1);
  assign sp_dec = sp - AW'(1);

  assign busy      = push_req | pop_req;
  assign vid_sel   = strobe & in_vid;
  assign per_sel   = strobe & in_per;
  assign per_slot  = in_per ? SLOT_W'(cpu_addr - PER_BASE) : '0;
  assign reg_hit   = strobe & in_reg;

  assign ram_we    = xf_act ? xf_push  : (cpu_ram & cpu_wr);
  assign ram_re    = xf_act ? !xf_push : (cpu_ram & cpu_rd);
  assign ram_addr  = xf_act ? xf_addr  : cpu_addr;
  assign ram_wdata = xf_act ? xf_data  : cpu_wdata;

  always_comb begin
    reg_rdata = '0;
    if (cpu_rd && in_reg) begin
      if (cpu_addr == SREG_ADDR)     reg_rdata = sreg;
      else if (cpu_addr == SPL_ADDR) reg_rdata = sp[DW-1:0];
      else                           reg_rdata = sp[AW-1:DW];
    end
  end

  always_comb begin
    sp_nxt = sp;
    if (push_req)     sp_nxt = sp_dec;
    else if (pop_req) sp_nxt = sp_inc;
    if (wr_spl)       sp_nxt = {sp[AW-1:DW], cpu_wdata};
    else if (wr_sph)  sp_nxt = {cpu_wdata, sp[DW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp      <= SP_INIT;
      sreg    <= '0;
      xf_act  <= 1'b0;
      xf_push <= 1'b0;
      xf_addr <= '0;
      xf_data <= '0;
    end else begin
      sp      <= sp_nxt;
      if (wr_srg) sreg <= cpu_wdata;
      xf_act  <= push_req | pop_req;
      xf_push <= push_req;
      xf_addr <= push_req ? sp : sp_inc;
      xf_data <= push_data;
    end
  end

  // R2
  push_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !wr_spl && !wr_sph) |=>
      (ram_we && !ram_re && ram_addr == $past(sp) && sp == AW'($past(sp) - AW'(1))));

  // R3
  pop_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && !wr_spl && !wr_sph) |=>
      (ram_re && !ram_we && ram_addr == sp && sp == AW'($past(sp) + AW'(1))));

  // R5
  region_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_ram, vid_sel, per_sel, reg_hit}));

  // R9
  spl_write_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_spl |=> (sp[DW-1:0] == $past(cpu_wdata) && sp[AW-1:DW] == $past(sp[AW-1:DW])));

  // R11
  push_over_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req) |=> (ram_we && !ram_re));

endmodule

// File: tb/tb_stack_mmio_decoder.sv
`timescale 1ns/1ps
module tb_stack_mmio_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0, push_data = '0;
  logic cpu_rd = 0, cpu_wr = 0, push_req = 0, pop_req = 0;
  logic [15:0] ram_addr;
  logic [7:0]  ram_wdata, reg_rdata;
  logic ram_we, ram_re, vid_sel, per_sel, reg_hit, busy;
  logic [5:0] per_slot;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stack_mmio_decoder dut (.clk, .rst_n, .cpu_addr, .cpu_wdata, .cpu_rd, .cpu_wr,
    .push_req, .pop_req, .push_data, .ram_addr, .ram_wdata, .ram_we, .ram_re,
    .vid_sel, .per_sel, .per_slot, .reg_hit, .reg_rdata, .busy);

  typedef struct {
    string tag; logic [15:0] ra; logic we, re; logic [7:0] wd;
    logic vid, per; logic [5:0] slot; logic hit; logic [7:0] rdat; logic bsy;
  } exp_t;
  exp_t q[$];

  logic [15:0] m_sp = 16'hEFFF, m_paddr = '0;
  logic [7:0]  m_sreg = '0, m_pdata = '0;
  logic m_pend = 0, m_ppush = 0;

  task automatic chk(string tag, string fld, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, fld, act, exp);
    end
  endtask

  task automatic step(string tag, logic [15:0] a, logic [7:0] wd, logic rd, logic wr,
                      logic ps, logic pp, logic [7:0] pd);
    exp_t e;
    logic strobe;
    logic [15:0] nsp;
    cpu_addr = a; cpu_wdata = wd; cpu_rd = rd; cpu_wr = wr;
    push_req = ps; pop_req = pp; push_data = pd;
    strobe = rd | wr;
    e.tag = tag; e.ra = '0; e.we = 0; e.re = 0; e.wd = '0; e.rdat = '0; e.bsy = ps | pp;
    if (m_pend) begin
      e.we = m_ppush; e.re = !m_ppush; e.ra = m_paddr; e.wd = m_pdata;
    end else if (a < 16'hF000 && strobe) begin
      e.we = wr; e.re = rd; e.ra = a; e.wd = wd;
    end
    e.vid = strobe && a >= 16'hF000 && a <= 16'hFFCF;
    e.per = strobe && a >= 16'hFFD0 && a <= 16'hFFFC;
    e.slot = e.per ? 6'(a - 16'hFFD0) : 6'd0;
    e.hit = strobe && a >= 16'hFFFD;
    if (rd && e.hit)
      e.rdat = (a == 16'hFFFF) ? m_sreg : (a == 16'hFFFE) ? m_sp[7:0] : m_sp[15:8];
    nsp = m_sp; m_pend = ps | pp; m_ppush = ps;
    if (ps) begin m_paddr = m_sp; m_pdata = pd; nsp = m_sp - 16'd1; end
    else if (pp) begin nsp = m_sp + 16'd1; m_paddr = nsp; end
    if (wr && a == 16'hFFFE) nsp = {m_sp[15:8], wd};
    if (wr && a == 16'hFFFD) nsp = {wd, m_sp[7:0]};
    if (wr && a == 16'hFFFF) m_sreg = wd;
    m_sp = nsp;
    #1 q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    step(tag, 16'h0000, 8'h00, 0, 0, 0, 0, 8'h00);
  endtask

  always begin
    @(negedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, "ram_we", 16'(ram_we), 16'(e.we));
      chk(e.tag, "ram_re", 16'(ram_re), 16'(e.re));
      if (e.we || e.re) chk(e.tag, "ram_addr", ram_addr, e.ra);
      if (e.we) chk(e.tag, "ram_wdata", 16'(ram_wdata), 16'(e.wd));
      chk(e.tag, "vid_sel", 16'(vid_sel), 16'(e.vid));
      chk(e.tag, "per_sel", 16'(per_sel), 16'(e.per));
      if (e.per) chk(e.tag, "per_slot", 16'(per_slot), 16'(e.slot));
      chk(e.tag, "reg_hit", 16'(reg_hit), 16'(e.hit));
      chk(e.tag, "reg_rdata", 16'(reg_rdata), 16'(e.rdat));
      chk(e.tag, "busy", 16'(busy), 16'(e.bsy));
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog run hung actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 idle after reset");
    step("R1 read sp low",  16'hFFFE, 0, 1, 0, 0, 0, 0);
    step("R1 read sp high", 16'hFFFD, 0, 1, 0, 0, 0, 0);
    step("R1 read status",  16'hFFFF, 0, 1, 0, 0, 0, 0);
    step("R4 ram write",    16'h1234, 8'h5A, 0, 1, 0, 0, 0);
    step("R4 ram read low", 16'h0000, 0, 1, 0, 0, 0, 0);
    step("R4 ram read top", 16'hEFFF, 0, 1, 0, 0, 0, 0);
    step("R5 video first",  16'hF000, 0, 1, 0, 0, 0, 0);
    step("R5 video last",   16'hFFCF, 8'h07, 0, 1, 0, 0, 0);
    step("R6 slot 0",       16'hFFD0, 0, 1, 0, 0, 0, 0);
    step("R6 slot 44",      16'hFFFC, 8'h33, 0, 1, 0, 0, 0);
    step("R6 no strobe",    16'hFFD5, 0, 0, 0, 0, 0, 0);
    step("R7 status write", 16'hFFFF, 8'hA5, 0, 1, 0, 0, 0);
    step("R7 status read",  16'hFFFF, 0, 1, 0, 0, 0, 0);
    step("R7 no read data", 16'hFFFF, 0, 0, 0, 0, 0, 0);
    step("R2 push 11",      16'h0000, 0, 0, 0, 1, 0, 8'h11);
    idle("R2 push transfer");
    step("R2 sp after push", 16'hFFFE, 0, 1, 0, 0, 0, 0);
    step("R3 pop",          16'h0000, 0, 0, 0, 0, 1, 0);
    idle("R3 pop transfer");
    step("R3 sp after pop", 16'hFFFE, 0, 1, 0, 0, 0, 0);
    step("R2 push 22",      16'h0000, 0, 0, 0, 1, 0, 8'h22);
    step("R2 push 33 back to back", 16'h0000, 0, 0, 0, 1, 0, 8'h33);
    step("R3 pop back to back", 16'h0000, 0, 0, 0, 0, 1, 0);
    step("R11 push with cpu ram write", 16'h0100, 8'h99, 0, 1, 1, 0, 8'h44);
    step("R11 transfer over cpu read", 16'h0200, 0, 1, 0, 0, 0, 0);
    step("R11 push and pop together", 16'h0000, 0, 0, 0, 1, 1, 8'h55);
    idle("R11 push wins transfer");
    step("R8 write sp low", 16'hFFFE, 8'h00, 0, 1, 0, 0, 0);
    step("R8 write sp high", 16'hFFFD, 8'h00, 0, 1, 0, 0, 0);
    step("R8 read sp low",  16'hFFFE, 0, 1, 0, 0, 0, 0);
    step("R10 push at zero", 16'h0000, 0, 0, 0, 1, 0, 8'h66);
    idle("R10 push transfer at zero");
    step("R10 sp high after wrap", 16'hFFFD, 0, 1, 0, 0, 0, 0);
    step("R10 pop at top",  16'h0000, 0, 0, 0, 0, 1, 0);
    idle("R10 pop reads zero");
    step("R10 sp low after wrap", 16'hFFFE, 0, 1, 0, 0, 0, 0);
    step("R8 set sp high",  16'hFFFD, 8'h80, 0, 1, 0, 0, 0);
    step("R8 set sp low",   16'hFFFE, 8'h10, 0, 1, 0, 0, 0);
    step("R9 push with sp low write", 16'hFFFE, 8'h40, 0, 1, 1, 0, 8'h77);
    step("R9 transfer old sp, read low", 16'hFFFE, 0, 1, 0, 0, 0, 0);
    step("R9 read high", 16'hFFFD, 0, 1, 0, 0, 0, 0);
    step("R9 pop with sp high write", 16'hFFFD, 8'h12, 0, 1, 0, 1, 0);
    step("R9 pop transfer, read high", 16'hFFFD, 0, 1, 0, 0, 0, 0);
    step("R9 read low after pop", 16'hFFFE, 0, 1, 0, 0, 0, 0);
    idle("final idle");
    idle("drain");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule